// File: doc/BRIEF.md
# Cipher Operation Launch Scheduler

This block decides when a block-cipher engine starts an operation and which operand the engine takes for it. Software can start an operation directly by writing a two-bit operand code. Hardware can also start one through auto-trigger rules. A rule can fire on a write to the last text word, on a read of the last text word, or on a write to the last buffer word. A buffer-word write is not lost when the engine is busy: it is held as a pending launch until the engine is free. A single-shot variant of the buffer rule disarms itself after one use. A DMA channel-A completion flag can suppress all auto-triggers, either at once or only after the operation that consumes the last channel-A data has started.

The scheduler presents a one-cycle `start` pulse with `start_src` to the engine. It then holds `busy` until the engine answers with `eng_done`. It also reports whether the buffer still holds an unconsumed block.

The FSM has two states:

- ST_IDLE, the engine is free. A granted launch moves it to ST_BUSY.
- ST_BUSY, an operation is running. `eng_done` or `abort` moves it back to ST_IDLE.

Top module: `cipher_launch_ctl`

## Requirements
- R1: After reset `busy`, `start` and `buf_full` are 0, no launch is pending and the single-shot rule is disarmed.
- R2: In ST_IDLE, a cycle with `man_wr`=1 and a nonzero `man_op` raises `start` in that same cycle. `start_src` then equals `man_op`, where 1 is TXT, 2 is BUF and 3 is TXT XOR BUF. A `man_op` of 0, or a manual write made in ST_BUSY, causes no launch.
- R3: `auto_mode` bit 0 lets `txt3_wr` launch and bit 1 lets `txt3_rd` launch. The launch happens in that same cycle with `start_src`=`src_sel`, and only in ST_IDLE, when not gated, when `src_sel`≠0 and when no higher-priority launch is present. Otherwise the event is dropped.
- R4: With `auto_mode` bit 2 set and `ctr_on`=0, a `buf3_wr` (not gated, `src_sel`≠0) makes a launch pending and captures `src_sel`. The pending launch starts in the first later ST_IDLE cycle that carries no manual launch. With `ctr_on`=1, bit 2 has no effect.
- R5: `auto_mode` bit 3 lets only the first `buf3_wr` after arming make a launch pending. The rule is armed by a `cfg_wr` cycle in which `auto_mode` bit 3 is 1.
- R6: At most one launch is pending at a time. A `buf3_wr` while one is pending adds nothing.
- R7: `buf_full` is 1 exactly while a launch is pending and `auto_mode` bit 2 is set. It is 0 whenever bit 2 is clear.
- R8: While `cha_done`=1, `gate_mode` bit 0 suppresses every auto-trigger (R3 launches and new R4/R5 pendings). `gate_mode` bit 1 suppresses them only once a launch has started while `cha_done` has been 1. Manual launches are never gated.
- R9: `abort` blocks any launch in its cycle, clears the pending launch and returns the FSM to ST_IDLE in the next cycle.
- R10: `busy` is 1 from the cycle after a `start` pulse until the cycle after `eng_done`. `eng_done` in ST_IDLE is ignored.
- R11: When several launches compete in one cycle, the manual launch wins over the pending launch, and the pending launch wins over a text auto-trigger. A losing text auto-trigger is dropped. A losing pending launch stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| man_wr | input | 1 | Manual operation field write strobe |
| man_op | input | 2 | Manual operand code (0 none, 1 TXT, 2 BUF, 3 TXT XOR BUF) |
| cfg_wr | input | 1 | Auto-trigger field write strobe (rearms single-shot) |
| auto_mode | input | 4 | Auto-trigger enables: bit0 TXT3 write, bit1 TXT3 read, bit2 BUF3 write, bit3 BUF3 write once |
| src_sel | input | 2 | Operand code for hardware launches, same encoding as `man_op` |
| ctr_on | input | 1 | Counter mode active, disables `auto_mode` bit 2 |
| txt3_wr | input | 1 | Bus write to the last text word |
| txt3_rd | input | 1 | Bus read of the last text word |
| buf3_wr | input | 1 | Bus write to the last buffer word |
| gate_mode | input | 2 | DMA gating: bit0 immediate, bit1 delayed |
| cha_done | input | 1 | DMA channel-A done flag |
| abort | input | 1 | Cancel running and pending operation |
| eng_done | input | 1 | Engine completion pulse |
| start | output | 1 | One-cycle operation start pulse |
| start_src | output | 2 | Operand code of the launch |
| busy | output | 1 | FSM state: 1 in ST_BUSY |
| buf_full | output | 1 | Buffer block not yet consumed |

## Verification
Directed sequences separate the launch paths. A manual code of 0 tests against a nonzero code, and a manual write in ST_IDLE against one in ST_BUSY. Buffer writes land while the engine is busy, which shows whether a launch is held pending or lost, and a second write tells one pending from two. The single-shot rule is run before and after rearming. Immediate and delayed gating are each tried with `cha_done` high, before and after a consumed launch. Long random runs then mix every strobe at once. These runs expose priority and drop errors that appear only when manual, pending and text triggers coincide with `eng_done` or `abort`.

// File: rtl/launch_pkg.sv
package launch_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } lstate_t;

    localparam int MODE_W    = 4;
    localparam int AM_TXT_WR = 0;
    localparam int AM_TXT_RD = 1;
    localparam int AM_BUF_WR = 2;
    localparam int AM_BUF_1X = 3;

    localparam int GATE_W    = 2;
    localparam int GM_NOW    = 0;
    localparam int GM_LATE   = 1;
endpackage

// File: rtl/launch_gate.sv
module launch_gate
    import launch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cha_done,
    input  logic [GATE_W-1:0] gate_mode,
    input  logic              start,
    output logic              gated
);
    // Remembers that a launch consumed channel-A data while the flag is up.
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (!cha_done) begin
            seen_q <= 1'b0;
        end else if (start) begin
            seen_q <= 1'b1;
        end
    end

    assign gated = cha_done & (gate_mode[GM_NOW] | (gate_mode[GM_LATE] & seen_q));
endmodule

// File: rtl/launch_bufsched.sv
module launch_bufsched
    import launch_pkg::*;
#(
    parameter int SRC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf3_wr,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] auto_mode,
    input  logic              ctr_on,
    input  logic              gated,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              take,
    input  logic              abort,
    output logic              pend,
    output logic [SRC_W-1:0]  pend_src,
    output logic              buf_full
);
    logic             pend_q;
    logic [SRC_W-1:0] psrc_q;
    logic             armed_q;
    logic             rule_ok;
    logic             sched;

    assign rule_ok = (auto_mode[AM_BUF_WR] & ~ctr_on) | (auto_mode[AM_BUF_1X] & armed_q);
    assign sched   = buf3_wr & rule_ok & ~pend_q & ~gated & ~abort & (src_sel != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            psrc_q <= '0;
        end else if (abort || take) begin
            pend_q <= 1'b0;
        end else if (sched) begin
            pend_q <= 1'b1;
            psrc_q <= src_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cfg_wr && auto_mode[AM_BUF_1X]) begin
            armed_q <= 1'b1;
        end else if (sched && auto_mode[AM_BUF_1X]) begin
            armed_q <= 1'b0;
        end
    end

    assign pend     = pend_q;
    assign pend_src = psrc_q;
    assign buf_full = pend_q & auto_mode[AM_BUF_WR];
endmodule

// File: rtl/launch_fsm.sv
module launch_fsm
    import launch_pkg::*;
#(
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_req,
    input  logic [SRC_W-1:0] man_src,
    input  logic             pend_req,
    input  logic [SRC_W-1:0] pend_src,
    input  logic             auto_req,
    input  logic [SRC_W-1:0] auto_src,
    input  logic             eng_done,
    input  logic             abort,
    output logic             start,
    output logic [SRC_W-1:0] start_src,
    output logic             take_pend,
    output logic             busy
);
    lstate_t state_q;
    lstate_t state_d;
    logic    grant;

    assign grant = (state_q == ST_IDLE) & ~abort & (man_req | pend_req | auto_req);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (grant) state_d = ST_BUSY;
            ST_BUSY: if (abort || eng_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start     = 1'b0;
        start_src = '0;
        take_pend = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (grant) begin
                    start = 1'b1;
                    if (man_req) begin
                        start_src = man_src;
                    end else if (pend_req) begin
                        start_src = pend_src;
                        take_pend = 1'b1;
                    end else begin
                        start_src = auto_src;
                    end
                end
            end
            ST_BUSY: begin
                start = 1'b0;
            end
            default: begin
                start = 1'b0;
            end
        endcase
    end

    assign busy = (state_q == ST_BUSY);
endmodule

// File: rtl/cipher_launch_ctl.sv
module cipher_launch_ctl
    import launch_pkg::*;
#(
    parameter int SRC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              man_wr,
    input  logic [SRC_W-1:0]  man_op,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] auto_mode,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              ctr_on,
    input  logic              txt3_wr,
    input  logic              txt3_rd,
    input  logic              buf3_wr,
    input  logic [GATE_W-1:0] gate_mode,
    input  logic              cha_done,
    input  logic              abort,
    input  logic              eng_done,
    output logic              start,
    output logic [SRC_W-1:0]  start_src,
    output logic              busy,
    output logic              buf_full
);
    logic             gated;
    logic             man_req;
    logic             auto_req;
    logic             pend_w;
    logic [SRC_W-1:0] pend_src_w;
    logic             take_w;

    assign man_req  = man_wr & (man_op != '0);
    assign auto_req = ((txt3_wr & auto_mode[AM_TXT_WR]) | (txt3_rd & auto_mode[AM_TXT_RD]))
                      & ~gated & (src_sel != '0);

    launch_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cha_done  (cha_done),
        .gate_mode (gate_mode),
        .start     (start),
        .gated     (gated)
    );

    launch_bufsched #(.SRC_W(SRC_W)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf3_wr   (buf3_wr),
        .cfg_wr    (cfg_wr),
        .auto_mode (auto_mode),
        .ctr_on    (ctr_on),
        .gated     (gated),
        .src_sel   (src_sel),
        .take      (take_w),
        .abort     (abort),
        .pend      (pend_w),
        .pend_src  (pend_src_w),
        .buf_full  (buf_full)
    );

    launch_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_req   (man_req),
        .man_src   (man_op),
        .pend_req  (pend_w),
        .pend_src  (pend_src_w),
        .auto_req  (auto_req),
        .auto_src  (src_sel),
        .eng_done  (eng_done),
        .abort     (abort),
        .start     (start),
        .start_src (start_src),
        .take_pend (take_w),
        .busy      (busy)
    );
endmodule

// File: rtl/launch_ctl_checker.sv
module launch_ctl_checker #(
    parameter int SRC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             man_wr,
    input logic [SRC_W-1:0] man_op,
    input logic [3:0]       auto_mode,
    input logic [1:0]       gate_mode,
    input logic             cha_done,
    input logic             abort,
    input logic             start,
    input logic [SRC_W-1:0] start_src,
    input logic             busy,
    input logic             buf_full,
    input logic             pend
);
    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!busy && start_src != '0));

    assert_busy_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !buf_full));

    assert_manual_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && man_wr && man_op != '0 && !abort) |-> (start && start_src == man_op));

    assert_full_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> auto_mode[2]);

    assert_gate_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cha_done && gate_mode[0] && !(man_wr && man_op != '0) && !pend) |-> !start);

    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !start && !abort) |=> pend);
endmodule

bind cipher_launch_ctl launch_ctl_checker #(.SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_wr    (man_wr),
    .man_op    (man_op),
    .auto_mode (auto_mode),
    .gate_mode (gate_mode),
    .cha_done  (cha_done),
    .abort     (abort),
    .start     (start),
    .start_src (start_src),
    .busy      (busy),
    .buf_full  (buf_full),
    .pend      (pend_w)
);

// File: tb/cipher_launch_ctl_tb.sv
`timescale 1ns/1ps
module cipher_launch_ctl_tb;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       man_wr, cfg_wr, ctr_on, txt3_wr, txt3_rd, buf3_wr, cha_done, abort, eng_done;
    logic [1:0] man_op, src_sel, gate_mode;
    logic [3:0] auto_mode;
    logic       start, busy, buf_full;
    logic [1:0] start_src;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    string       tag = "R1";

    // reference state
    bit       r_busy, r_pend, r_armed, r_seen;
    bit [1:0] r_psrc;
    int       eng_cnt;

    always #2.5 clk = ~clk;

    cipher_launch_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .man_wr(man_wr), .man_op(man_op), .cfg_wr(cfg_wr),
        .auto_mode(auto_mode), .src_sel(src_sel), .ctr_on(ctr_on), .txt3_wr(txt3_wr),
        .txt3_rd(txt3_rd), .buf3_wr(buf3_wr), .gate_mode(gate_mode), .cha_done(cha_done),
        .abort(abort), .eng_done(eng_done), .start(start), .start_src(start_src),
        .busy(busy), .buf_full(buf_full)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act %0d exp %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit is_gated();
        return cha_done && (gate_mode[0] || (gate_mode[1] && r_seen));
    endfunction

    // One clock: inputs already driven; compare, advance reference, clear strobes.
    task automatic step();
        bit       e_start, from_pend, auto_ok, sched, g;
        bit [1:0] e_src;
        eng_done = (eng_cnt == 1);
        g        = is_gated();
        auto_ok  = ((txt3_wr && auto_mode[0]) || (txt3_rd && auto_mode[1])) && !g && src_sel != 0;
        e_start = 0; e_src = 0; from_pend = 0;
        if (!r_busy && !abort) begin
            if (man_wr && man_op != 0) begin e_start = 1; e_src = man_op; end
            else if (r_pend)           begin e_start = 1; e_src = r_psrc; from_pend = 1; end
            else if (auto_ok)          begin e_start = 1; e_src = src_sel; end
        end
        @(negedge clk);
        check("start (R2/R3/R11)", start, e_start);
        if (e_start) check("start_src (R2/R4)", start_src, e_src);
        check("busy (R10)", busy, r_busy);
        check("buf_full (R7)", buf_full, r_pend && auto_mode[2]);
        sched = buf3_wr && !r_pend && !g && !abort && src_sel != 0 &&
                ((auto_mode[2] && !ctr_on) || (auto_mode[3] && r_armed));
        @(posedge clk);
        if (abort) r_busy = 0;
        else if (e_start) r_busy = 1;
        else if (r_busy && eng_done) r_busy = 0;
        if (abort || from_pend) r_pend = 0;
        else if (sched) begin r_pend = 1; r_psrc = src_sel; end
        if (cfg_wr && auto_mode[3]) r_armed = 1;
        else if (sched && auto_mode[3]) r_armed = 0;
        if (!cha_done) r_seen = 0;
        else if (e_start) r_seen = 1;
        if (abort) eng_cnt = 0;
        else if (e_start) eng_cnt = LAT;
        else if (eng_cnt != 0) eng_cnt--;
        #1;
        man_wr = 0; cfg_wr = 0; txt3_wr = 0; txt3_rd = 0; buf3_wr = 0; abort = 0;
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic bit one_in(input int n);
        return ($urandom % n) == 0;
    endfunction

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0011));
        rst_n = 0; man_wr = 0; man_op = 0; cfg_wr = 0; auto_mode = 0; src_sel = 1;
        ctr_on = 0; txt3_wr = 0; txt3_rd = 0; buf3_wr = 0; gate_mode = 0; cha_done = 0;
        abort = 0; eng_done = 0;
        r_busy = 0; r_pend = 0; r_armed = 0; r_seen = 0; r_psrc = 0; eng_cnt = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        tag = "R1";
        check("reset busy", busy, 0);
        check("reset start", start, 0);
        check("reset buf_full", buf_full, 0);
        @(posedge clk); #1;

        // R2: manual codes, zero code, busy drop
        tag = "R2";
        man_wr = 1; man_op = 0; step();
        man_wr = 1; man_op = 2; step();
        man_wr = 1; man_op = 3; step();
        idle_steps(6);

        // R5: single shot arms, fires once, rearms
        tag = "R5";
        auto_mode = 4'b1000; src_sel = 3; buf3_wr = 1; step();
        idle_steps(2);
        cfg_wr = 1; step();
        buf3_wr = 1; step();
        idle_steps(7);
        buf3_wr = 1; step();
        idle_steps(3);
        cfg_wr = 1; step();
        buf3_wr = 1; step();
        idle_steps(7);

        // R6 and R7: pending during busy, second write adds nothing
        tag = "R6";
        auto_mode = 4'b0100; src_sel = 2;
        man_wr = 1; man_op = 1; step();
        buf3_wr = 1; step();
        buf3_wr = 1; step();
        idle_steps(12);

        // R4: counter mode disables the buffer rule
        tag = "R4";
        ctr_on = 1; buf3_wr = 1; step();
        idle_steps(3);
        ctr_on = 0;

        // R8: immediate and delayed gating
        tag = "R8";
        auto_mode = 4'b0011; src_sel = 1; cha_done = 1; gate_mode = 2'b01;
        txt3_wr = 1; step();
        txt3_rd = 1; step();
        man_wr = 1; man_op = 2; step();
        idle_steps(6);
        cha_done = 0; step();
        gate_mode = 2'b10; cha_done = 1;
        txt3_wr = 1; step();
        idle_steps(6);
        txt3_wr = 1; step();
        idle_steps(2);
        cha_done = 0; gate_mode = 0; step();

        // R9: abort while busy and with pending launch
        tag = "R9";
        auto_mode = 4'b0100; src_sel = 3;
        man_wr = 1; man_op = 1; step();
        buf3_wr = 1; step();
        abort = 1; step();
        idle_steps(4);

        // R11 and R3: mixed random traffic
        tag = "R11";
        for (int c = 0; c < 4000; c++) begin
            if (one_in(40)) auto_mode = 4'($urandom);
            if (one_in(30)) src_sel = (one_in(8)) ? 2'd0 : 2'(1 + $urandom % 3);
            if (one_in(50)) ctr_on = one_in(4);
            if (one_in(60)) gate_mode = 2'(one_in(2) ? 1 : 2) & {2{one_in(2)}};
            if (one_in(25)) cha_done = one_in(3);
            man_wr  = one_in(12);
            man_op  = 2'($urandom);
            cfg_wr  = one_in(20);
            txt3_wr = one_in(5);
            txt3_rd = one_in(7);
            buf3_wr = one_in(4);
            abort   = one_in(70);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule